// File: doc/BRIEF.md
# Dual-Bank I2C Register Slave

This block is the serial front end of a small byte-addressed register space. It sits on a two-wire I2C bus as a slave. It answers to two 7-bit device addresses: one selects a control/status bank and the other selects a general storage bank. Both banks share one word-address pointer. The block supports four transfer types:

- a single-byte write;
- a read that starts at the current pointer;
- a random read, where a dummy write sets the pointer;
- a sequential read, where the pointer steps after each byte and wraps from 2Fh back to 00h.

SCL and SDA are oversampled by the system clock through synchronisers. SDA is driven open-drain: `sda_oe` high pulls the line low.

On the back end the block drives a simple register-file port. It provides an address, a bank select, write data, and single-cycle read and write strobes. The register file returns read data one clock cycle after it sees the read strobe. A battery-backup input removes the block from the bus entirely.

Top module: `i2c_dual_bank_slave`

## Requirements
- R1: A device byte (7-bit address, MSB first, then the R/W bit, 1 = read) is acknowledged only when its address is 1101111 (control bank, `rf_bank`=0) or 1010111 (storage bank, `rf_bank`=1). Any other address is not acknowledged and causes no strobe.
- R2: In a write transfer, the block acknowledges the device byte (R/W=0), the word address byte and one data byte. The word address loads the pointer. The data byte produces exactly one `rf_wr` pulse carrying that address, the header's bank and the received data.
- R3: After reset the pointer is 00h, so a read with no prior word address returns location 00h first. After reset `sda_oe`, `rf_rd` and `rf_wr` are low.
- R4: A random read consists of a dummy write header, a word address, a repeated START and a read header naming the same bank. All three bytes are acknowledged, and the block then returns data from the given address, MSB first.
- R5: While the master acknowledges each byte, further bytes are sent. The pointer advances by one for each byte sent, and after 2Fh it becomes 00h.
- R6: A read header after a repeated START that names a different bank from the preceding dummy write is not acknowledged and causes no read strobe.
- R7: After the master NACKs a data byte, the block releases SDA and issues no further read strobe.
- R8: While `batt_backup` is high, all bus activity is ignored: `sda_oe` stays low and no strobe is issued.
- R9: `sda_oe` changes only while SCL is low.
- R10: A write leaves the pointer at the written location. Any data byte after the first in one write transfer is neither acknowledged nor written.
- R11: `rf_rd` and `rf_wr` are never high together, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| batt_backup | input | 1 | High while running from backup supply; bus disabled |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| rf_addr | output | AW | Register-file address |
| rf_bank | output | 1 | 0 = control/status bank, 1 = storage bank |
| rf_rd | output | 1 | Single-cycle read strobe |
| rf_wr | output | 1 | Single-cycle write strobe |
| rf_wdata | output | 8 | Write data |
| rf_rdata | input | 8 | Read data, valid one cycle after `rf_rd` |

## Verification
A corrupted pointer appears on the first data byte of the next read. It shows either as a wrong `rf_addr` at the read strobe or as wrong bits on SDA within that byte, which is why the wrap test reads across 2Fh. A wrong bank latch or a stale dummy-write flag shows one byte earlier, as an acknowledge where a NACK was due (or the reverse) in the ninth clock of the read header. A controller state that drifts by one bit misaligns the acknowledge slot and is caught at the very next byte boundary.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  localparam int BYTE = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SKIP,
    ST_DEV,
    ST_DEV_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_TX,
    ST_TX_ACK
  } ctl_state_t;

  localparam logic BANK_CTRL = 1'b0;
  localparam logic BANK_STORE = 1'b1;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_word_ptr.sv
module i2c_word_ptr #(
  parameter int          AW   = 8,
  parameter logic [AW-1:0] LAST = 8'h2F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_rs_pkg::*;
#(
  parameter int         AW      = 8,
  parameter logic [6:0] CTRL_ID = 7'b1101111,
  parameter logic [6:0] STORE_ID = 7'b1010111
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            batt,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic [AW-1:0]   ptr,
  output logic            ptr_load,
  output logic [AW-1:0]   ptr_val,
  output logic            ptr_inc,
  output logic            sda_oe,
  output logic [AW-1:0]   rf_addr,
  output logic            rf_bank,
  output logic            rf_rd,
  output logic            rf_wr,
  output logic [BYTE-1:0] rf_wdata,
  input  logic [BYTE-1:0] rf_rdata
);
  localparam int CW = $clog2(BYTE + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE - 1);
  localparam logic [CW-1:0] ALL_BITS = CW'(BYTE);

  ctl_state_t      state;
  logic [CW-1:0]   bitcnt;
  logic [BYTE-2:0] rx_sh;
  logic [BYTE-1:0] tx_sh;
  logic [BYTE-1:0] rx_byte;
  logic            hdr_valid, hdr_bank, cur_rw, ack_on, tx_more, rd_pend;
  logic            dev_hit, byte_bank, bank_clash;

  assign rx_byte    = {rx_sh, sda_s};
  assign byte_bank  = (rx_byte[7:1] == STORE_ID);
  assign dev_hit    = (rx_byte[7:1] == STORE_ID) || (rx_byte[7:1] == CTRL_ID);
  assign bank_clash = rx_byte[0] && hdr_valid && (hdr_bank != byte_bank);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;   bitcnt <= '0;     rx_sh <= '0;     tx_sh <= '0;
      hdr_valid <= 1'b0;  hdr_bank <= BANK_CTRL; cur_rw <= 1'b0;
      ack_on <= 1'b0;     tx_more <= 1'b0;  rd_pend <= 1'b0;
      sda_oe <= 1'b0;     rf_addr <= '0;    rf_bank <= BANK_CTRL;
      rf_rd <= 1'b0;      rf_wr <= 1'b0;    rf_wdata <= '0;
      ptr_load <= 1'b0;   ptr_val <= '0;    ptr_inc <= 1'b0;
    end else begin
      rf_rd    <= 1'b0;
      rf_wr    <= 1'b0;
      ptr_load <= 1'b0;
      ptr_inc  <= 1'b0;
      rd_pend  <= rf_rd;
      if (rd_pend) tx_sh <= rf_rdata;
      if (batt) begin
        state <= ST_IDLE; sda_oe <= 1'b0; ack_on <= 1'b0; hdr_valid <= 1'b0;
      end else if (start_det) begin
        state <= ST_DEV; bitcnt <= '0; sda_oe <= 1'b0; ack_on <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE; sda_oe <= 1'b0; ack_on <= 1'b0; hdr_valid <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_ADDR, ST_WDAT: if (scl_rise) begin
            rx_sh  <= rx_byte[BYTE-2:0];
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              if (state == ST_DEV) begin
                if (dev_hit && !bank_clash) begin
                  state   <= ST_DEV_ACK;
                  cur_rw  <= rx_byte[0];
                  rf_bank <= byte_bank;
                  if (rx_byte[0]) begin
                    rf_rd     <= 1'b1;
                    rf_addr   <= ptr;
                    ptr_inc   <= 1'b1;
                    hdr_valid <= 1'b0;
                  end else begin
                    hdr_valid <= 1'b1;
                    hdr_bank  <= byte_bank;
                  end
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_ADDR) begin
                ptr_load <= 1'b1;
                ptr_val  <= rx_byte[AW-1:0];
                state    <= ST_ADDR_ACK;
              end else begin
                rf_wr     <= 1'b1;
                rf_addr   <= ptr;
                rf_wdata  <= rx_byte;
                hdr_valid <= 1'b0;
                state     <= ST_WDAT_ACK;
              end
            end
          end
          ST_DEV_ACK, ST_ADDR_ACK, ST_WDAT_ACK: if (scl_fall) begin
            if (!ack_on) begin
              sda_oe <= 1'b1;
              ack_on <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              sda_oe <= 1'b0;
              bitcnt <= '0;
              if (state == ST_ADDR_ACK)      state <= ST_WDAT;
              else if (state == ST_WDAT_ACK) state <= ST_SKIP;
              else if (!cur_rw)              state <= ST_ADDR;
              else begin
                state  <= ST_TX;
                sda_oe <= ~tx_sh[BYTE-1];
                tx_sh  <= {tx_sh[BYTE-2:0], 1'b0};
              end
            end
          end
          ST_TX: begin
            if (scl_rise) bitcnt <= bitcnt + 1'b1;
            else if (scl_fall) begin
              if (bitcnt == ALL_BITS) begin
                sda_oe  <= 1'b0;
                tx_more <= 1'b0;
                state   <= ST_TX_ACK;
              end else begin
                sda_oe <= ~tx_sh[BYTE-1];
                tx_sh  <= {tx_sh[BYTE-2:0], 1'b0};
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                rf_rd   <= 1'b1;
                rf_addr <= ptr;
                ptr_inc <= 1'b1;
                tx_more <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end else if (scl_fall && tx_more) begin
              tx_more <= 1'b0;
              bitcnt  <= '0;
              state   <= ST_TX;
              sda_oe  <= ~tx_sh[BYTE-1];
              tx_sh   <= {tx_sh[BYTE-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_dual_bank_slave.sv
module i2c_dual_bank_slave
  import i2c_rs_pkg::*;
#(
  parameter int            AW          = 8,
  parameter int            SYNC_STAGES = 2,
  parameter logic [6:0]    CTRL_ID     = 7'b1101111,
  parameter logic [6:0]    STORE_ID    = 7'b1010111,
  parameter logic [AW-1:0] PTR_LAST    = 8'h2F
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            batt_backup,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  output logic [AW-1:0]   rf_addr,
  output logic            rf_bank,
  output logic            rf_rd,
  output logic            rf_wr,
  output logic [BYTE-1:0] rf_wdata,
  input  logic [BYTE-1:0] rf_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ptr_load, ptr_inc;
  logic [AW-1:0] ptr_val, ptr_q;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_word_ptr #(.AW(AW), .LAST(PTR_LAST)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_val),
    .inc(ptr_inc), .ptr(ptr_q)
  );

  i2c_slave_ctrl #(.AW(AW), .CTRL_ID(CTRL_ID), .STORE_ID(STORE_ID)) u_ctrl (
    .clk(clk), .rst(rst), .batt(batt_backup), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .ptr(ptr_q), .ptr_load(ptr_load), .ptr_val(ptr_val),
    .ptr_inc(ptr_inc), .sda_oe(sda_oe), .rf_addr(rf_addr), .rf_bank(rf_bank),
    .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );
endmodule

// File: rtl/i2c_dual_bank_slave_chk.sv
module i2c_dual_bank_slave_chk #(
  parameter int            AW   = 8,
  parameter logic [AW-1:0] LAST = 8'h2F
) (
  input logic          clk,
  input logic          rst,
  input logic          batt,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          rf_rd,
  input logic          rf_wr,
  input logic [AW-1:0] rf_addr,
  input logic [AW-1:0] ptr
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rf_rd && rf_wr)); // R11
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    rf_rd |=> !rf_rd); // R11
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
    rf_wr |=> !rf_wr); // R11
  AST_BATT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    batt |=> !sda_oe); // R8
  AST_BATT_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    batt |=> (!rf_rd && !rf_wr)); // R8
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(batt)) |-> !scl_s); // R9
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    $past(rf_rd, 2) |->
      (ptr == (($past(rf_addr, 2) == LAST) ? '0 : $past(rf_addr, 2) + 1'b1))); // R5
endmodule

bind i2c_dual_bank_slave i2c_dual_bank_slave_chk #(.AW(AW), .LAST(PTR_LAST)) u_chk (
  .clk(clk), .rst(rst), .batt(batt_backup), .scl_s(scl_s), .sda_oe(sda_oe),
  .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_addr(rf_addr), .ptr(ptr_q)
);

// File: tb/i2c_dual_bank_slave_bench.sv
module i2c_dual_bank_slave_bench;
  localparam int Q = 10;
  localparam logic [7:0] CW_ = 8'hDE, CR_ = 8'hDF, SW_ = 8'hAE, SR_ = 8'hAF;

  logic clk = 1'b0, rst = 1'b1, batt = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, rf_bank, rf_rd, rf_wr;
  logic [7:0] rf_addr, rf_wdata, rf_rdata;
  logic sda_line;
  logic [7:0] ctrl_mem [256];
  logic [7:0] store_mem [256];
  int checks = 0, fails = 0, rd_cnt = 0, wr_cnt = 0;
  logic [7:0] last_wa, last_wd;
  logic last_wb;
  int scl_viol = 0, strobe_viol = 0, batt_drive = 0;
  logic prev_oe = 1'b0, prev_rd = 1'b0, prev_wr = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_dual_bank_slave u_i2c_dual_bank_slave (
    .clk(clk), .rst(rst), .batt_backup(batt), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .rf_addr(rf_addr), .rf_bank(rf_bank), .rf_rd(rf_rd),
    .rf_wr(rf_wr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  initial begin
    for (int i = 0; i < 256; i++) begin
      ctrl_mem[i]  = 8'(i) ^ 8'hA5;
      store_mem[i] = 8'(i) + 8'h30;
    end
  end

  always @(posedge clk) begin
    if (rf_wr) begin
      if (rf_bank) store_mem[rf_addr] <= rf_wdata; else ctrl_mem[rf_addr] <= rf_wdata;
      wr_cnt <= wr_cnt + 1; last_wa <= rf_addr; last_wd <= rf_wdata; last_wb <= rf_bank;
    end
    if (rf_rd) begin
      rf_rdata <= rf_bank ? store_mem[rf_addr] : ctrl_mem[rf_addr];
      rd_cnt <= rd_cnt + 1;
    end
    if (!rst) begin
      if (sda_oe !== prev_oe && scl_m && !batt) scl_viol <= scl_viol + 1;
      if ((rf_rd && rf_wr) || (rf_rd && prev_rd) || (rf_wr && prev_wr)) strobe_viol <= strobe_viol + 1;
      if (batt && sda_oe) batt_drive <= batt_drive + 1;
    end
    prev_oe <= sda_oe; prev_rd <= rf_rd; prev_wr <= rf_wr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitq(); repeat (Q) @(negedge clk); endtask
  task automatic wbit(input logic b);
    sda_m = b; waitq(); scl_m = 1'b1; waitq(); waitq(); scl_m = 1'b0; waitq();
  endtask
  task automatic rbit(output logic v);
    sda_m = 1'b1; waitq(); scl_m = 1'b1; waitq(); v = sda_line; waitq(); scl_m = 1'b0; waitq();
  endtask
  task automatic bus_start();
    sda_m = 1'b1; waitq(); scl_m = 1'b1; waitq(); sda_m = 1'b0; waitq(); scl_m = 1'b0; waitq();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; waitq(); scl_m = 1'b1; waitq(); sda_m = 1'b1; waitq(); waitq();
  endtask
  task automatic send(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(v); ack = ~v;
  endtask
  task automatic recv(input logic mack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin rbit(v); b[i] = v; end
    wbit(~mack);
  endtask

  task automatic t_reset();
    chk("R3 sda_oe after reset", 32'(sda_oe), 0);
    chk("R3 rf_rd after reset", 32'(rf_rd), 0);
    chk("R3 rf_wr after reset", 32'(rf_wr), 0);
  endtask

  task automatic t_current_after_reset();
    logic a; logic [7:0] d;
    bus_start(); send(CR_, a); chk("R1 control read header ack", 32'(a), 1);
    recv(1'b1, d); chk("R3 first byte from 00h", 32'(d), 32'h00 ^ 32'hA5);
    recv(1'b0, d); chk("R5 second byte from 01h", 32'(d), 32'h01 ^ 32'hA5);
    bus_stop();
  endtask

  task automatic t_bad_address();
    logic a; int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    bus_start(); send(8'hA0, a); chk("R1 foreign address nack", 32'(a), 0); bus_stop();
    bus_start(); send(8'hDC, a); chk("R1 near-miss address nack", 32'(a), 0); bus_stop();
    chk("R1 no strobes for foreign address", 32'(rd_cnt - r0 + wr_cnt - w0), 0);
  endtask

  task automatic t_write();
    logic a1, a2, a3; int w0;
    w0 = wr_cnt;
    bus_start(); send(SW_, a1); send(8'h10, a2); send(8'h5C, a3); bus_stop();
    chk("R2 three acks", {29'd0, a1, a2, a3}, 32'h7);
    chk("R2 one write strobe", 32'(wr_cnt - w0), 1);
    chk("R2 write address", 32'(last_wa), 32'h10);
    chk("R2 write bank", 32'(last_wb), 1);
    chk("R2 write data", 32'(last_wd), 32'h5C);
  endtask

  task automatic t_extra_byte();
    logic a; logic [7:0] d; int w0;
    w0 = wr_cnt;
    bus_start(); send(SW_, a); send(8'h20, a); send(8'h77, a);
    send(8'h88, a); chk("R10 extra data byte nack", 32'(a), 0); bus_stop();
    chk("R10 only one write", 32'(wr_cnt - w0), 1);
    bus_start(); send(SR_, a); recv(1'b0, d); bus_stop();
    chk("R10 pointer stays at written location", 32'(d), 32'h77);
  endtask

  task automatic t_random_read();
    logic a1, a2, a3; logic [7:0] d; int r0;
    bus_start(); send(CW_, a1); send(8'h05, a2); bus_start(); send(CR_, a3);
    r0 = rd_cnt;
    chk("R4 three acks", {29'd0, a1, a2, a3}, 32'h7);
    recv(1'b1, d); chk("R4 byte at 05h", 32'(d), 32'h05 ^ 32'hA5);
    recv(1'b1, d); chk("R5 byte at 06h", 32'(d), 32'h06 ^ 32'hA5);
    recv(1'b0, d); chk("R5 byte at 07h", 32'(d), 32'h07 ^ 32'hA5);
    repeat (30) @(negedge clk);
    chk("R7 SDA released after nack", 32'(sda_oe), 0);
    chk("R7 no strobe after nack", 32'(rd_cnt - r0), 2);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic a; logic [7:0] d;
    bus_start(); send(SW_, a); send(8'h2E, a); bus_start(); send(SR_, a);
    recv(1'b1, d); chk("R5 byte at 2Eh", 32'(d), 32'h5E);
    recv(1'b1, d); chk("R5 byte at 2Fh", 32'(d), 32'h5F);
    recv(1'b1, d); chk("R5 wrap to 00h", 32'(d), 32'h30);
    recv(1'b0, d); chk("R5 then 01h", 32'(d), 32'h31);
    bus_stop();
  endtask

  task automatic t_bank_clash();
    logic a; logic [7:0] d; int r0;
    bus_start(); send(CW_, a); send(8'h08, a); bus_start();
    r0 = rd_cnt;
    send(SR_, a); chk("R6 mismatched read header nack", 32'(a), 0);
    chk("R6 no read strobe", 32'(rd_cnt - r0), 0);
    bus_stop();
    bus_start(); send(CR_, a); recv(1'b0, d); bus_stop();
    chk("R6 fresh read header accepted", 32'(d), 32'h08 ^ 32'hA5);
  endtask

  task automatic t_battery();
    logic a1, a2, a3; logic [7:0] d; int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    batt = 1'b1; waitq();
    bus_start(); send(SW_, a1); send(8'h30, a2); send(8'h99, a3); bus_stop();
    chk("R8 no acks in backup", {29'd0, a1, a2, a3}, 0);
    chk("R8 no strobes in backup", 32'(wr_cnt - w0 + rd_cnt - r0), 0);
    chk("R8 SDA never driven in backup", 32'(batt_drive), 0);
    batt = 1'b0; waitq();
    bus_start(); send(SW_, a1); send(8'h30, a1); bus_start(); send(SR_, a1);
    recv(1'b0, d); bus_stop();
    chk("R8 location untouched by backup traffic", 32'(d), 32'h60);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_current_after_reset();
    t_bad_address();
    t_write();
    t_extra_byte();
    t_random_read();
    t_wrap();
    t_bank_clash();
    t_battery();
    chk("R9 SDA changed only with SCL low", 32'(scl_viol), 0);
    chk("R11 strobes exclusive single-cycle", 32'(strobe_viol), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule